// File: doc/BRIEF.md
# Serial Configuration and Result Interface for a Multi-Channel Converter

This block is the digital front end of a multi-channel successive-approximation converter. A host reaches it over a four-wire, full-duplex synchronous link: an active-low chip select, a shift clock, serial data in and serial data out. Each chip-select frame carries two things at once. The host shifts in an 8-bit configuration word. The block shifts out the result of the conversion that the previous frame requested.

When a frame closes with a complete configuration word, the block latches the word and issues a one-clock conversion request to the converter core. It then holds a busy flag until the core reports done, and stores the core's 12-bit result at that point. The configuration word sets the output format for the next frame: bit order and word length. It also carries the channel mode, the channel select and the polarity, which go out to the core.

All link inputs are oversampled in the system clock domain through two-stage synchronizers. Edge detection runs in that domain, so the shift clock must be slow compared with the system clock.

Top module: `adc_sercfg`

## Requirements
- R1: After reset, sdo_o, busy_o and conv_req_o are 0 and cfg_o is 8'h8D. The first frame shifts out a zero result.
- R2: The configuration is taken from the first eight rising shift-clock edges of a frame, first bit into cfg_o[7]. The field layout from bit 7 down to bit 0 is: single-ended, odd/sign, channel select [1:0], unipolar, MSB-first, length code [1:0]. Data-in bits after the eighth rising edge of the same frame have no effect.
- R3: A frame that ends with eight bits captured while the block is idle updates cfg_o. In that case conv_req_o pulses for exactly one system clock and busy_o goes high.
- R4: A frame with fewer than eight rising shift-clock edges changes neither cfg_o nor busy_o and raises no request.
- R5: core_done_i while busy clears busy_o and stores core_result_i. core_done_i while idle is ignored, and the stored result stays the same.
- R6: Each frame shifts out the result stored when the frame began, formatted by the cfg_o in force during that frame. Results therefore lag their request by one frame.
- R7: The first output bit is valid from frame start, before the first rising shift-clock edge. Each later bit follows a falling edge, and the host samples on the rising edge.
- R8: Length code 00 sends the upper 8 result bits and 01 sends all 12. Codes 10 and 11 send 16 bits: the 12 result bits followed by four zeros. Output bits beyond the length are 0.
- R9: With the MSB-first bit at 1, the selected bits go out most significant first. With it at 0, the same selected bits go out in reverse order.
- R10: sdo_o is 0 while chip select is high.
- R11: A frame that ends while busy raises no request and leaves cfg_o unchanged. A frame that starts while busy shifts out the last completed result.
- R12: If core_done_i arrives in the same system clock in which a complete frame ends, the result is stored and the new request is accepted, and busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Shift clock from host, idle low |
| sdi_i | input | 1 | Serial configuration data from host |
| sdo_o | output | 1 | Serial result data to host |
| conv_req_o | output | 1 | One-clock conversion request to core |
| cfg_o | output | 8 | Latched configuration word |
| busy_o | output | 1 | Conversion outstanding |
| core_done_i | input | 1 | Core conversion complete strobe |
| core_result_i | input | RES_W (12) | Core conversion result |

## Verification
The tightest collision is the core's done strobe landing in the same system clock as the synchronized rising chip select that closes a complete frame. In that clock the block must retire the old conversion and accept the new one. The bench disables its core model, leaves a request outstanding, and drives done by hand so that it coincides with the clock that detects the frame end. The outcome is judged in three ways. The request counter must advance, busy_o must remain high and cfg_o must take the new word. A following frame, started while still busy, must shift out the collided result in the new format.

// File: rtl/adc_sercfg_pkg.sv
package adc_sercfg_pkg;

  typedef struct packed {
    logic       single_end;
    logic       odd_sign;
    logic [1:0] chan_sel;
    logic       unipolar;
    logic       msb_first;
    logic [1:0] len_code;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

  localparam cfg_t CFG_RST = '{
    single_end: 1'b1,
    odd_sign:   1'b0,
    chan_sel:   2'b00,
    unipolar:   1'b1,
    msb_first:  1'b1,
    len_code:   2'b01
  };

endpackage

// File: rtl/adc_sercfg_sync.sv
module adc_sercfg_sync #(
  parameter int unsigned     WIDTH   = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/adc_sercfg_frame.sv
module adc_sercfg_frame
  import adc_sercfg_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned OUT_W = 16,
  localparam int unsigned IDX_W = $clog2(OUT_W + 1),
  localparam int unsigned CNT_W = $clog2(CFG_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             core_done_i,
  input  logic [RES_W-1:0] core_result_i,
  output logic             frame_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic [RES_W-1:0] word_o,
  output cfg_t             cfg_o,
  output logic             busy_o,
  output logic             conv_req_o
);

  logic             cs_prev_q, sck_prev_q;
  logic             frame_q, busy_q, req_q;
  logic [CNT_W-1:0] in_cnt_q;
  logic [CFG_W-1:0] shift_q;
  logic [IDX_W-1:0] out_idx_q;
  logic [RES_W-1:0] result_q, word_q;
  cfg_t             cfg_q;

  logic cs_fall, cs_rise, sck_rise, sck_fall, accept;

  assign cs_fall  = cs_prev_q & ~cs_n_i;
  assign cs_rise  = ~cs_prev_q & cs_n_i;
  assign sck_rise = ~sck_prev_q & sck_i;
  assign sck_fall = sck_prev_q & ~sck_i;
  // done in the same clock frees the slot for the new request
  assign accept   = cs_rise & frame_q & (in_cnt_q == CNT_W'(CFG_W)) &
                    (~busy_q | core_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
      frame_q    <= 1'b0;
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
      in_cnt_q   <= '0;
      shift_q    <= '0;
      out_idx_q  <= '0;
      result_q   <= '0;
      word_q     <= '0;
      cfg_q      <= CFG_RST;
    end else begin
      cs_prev_q  <= cs_n_i;
      sck_prev_q <= sck_i;
      req_q      <= accept;

      if (accept) cfg_q <= cfg_t'(shift_q);

      if (accept)           busy_q <= 1'b1;
      else if (core_done_i) busy_q <= 1'b0;

      if (core_done_i && busy_q) result_q <= core_result_i;

      if (cs_fall) begin
        frame_q   <= 1'b1;
        in_cnt_q  <= '0;
        out_idx_q <= '0;
        word_q    <= result_q;
      end else if (cs_rise) begin
        frame_q <= 1'b0;
      end else if (frame_q) begin
        if (sck_rise && in_cnt_q < CNT_W'(CFG_W)) begin
          shift_q  <= {shift_q[CFG_W-2:0], sdi_i};
          in_cnt_q <= in_cnt_q + 1'b1;
        end
        if (sck_fall && out_idx_q < IDX_W'(OUT_W))
          out_idx_q <= out_idx_q + 1'b1;
      end
    end
  end

  assign frame_o    = frame_q;
  assign out_idx_o  = out_idx_q;
  assign word_o     = word_q;
  assign cfg_o      = cfg_q;
  assign busy_o     = busy_q;
  assign conv_req_o = req_q;

endmodule

// File: rtl/adc_sercfg_fmt.sv
module adc_sercfg_fmt
  import adc_sercfg_pkg::*;
#(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned SHORT_W = 8,
  localparam int unsigned IDX_W = $clog2(OUT_W + 1),
  localparam int unsigned POS_W = $clog2(OUT_W)
) (
  input  logic             frame_i,
  input  logic [RES_W-1:0] word_i,
  input  cfg_t             cfg_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);

  logic [OUT_W-1:0] ext;
  logic [IDX_W-1:0] len;
  logic [POS_W-1:0] pos;

  always_comb begin
    ext = {word_i, {(OUT_W-RES_W){1'b0}}};
    unique case (cfg_i.len_code)
      2'b00:   len = IDX_W'(SHORT_W);
      2'b01:   len = IDX_W'(RES_W);
      default: len = IDX_W'(OUT_W);
    endcase
    // selected bits occupy ext[OUT_W-1 -: len]
    if (cfg_i.msb_first) pos = POS_W'(IDX_W'(OUT_W - 1) - idx_i);
    else                 pos = POS_W'(IDX_W'(OUT_W) - len + idx_i);
    bit_o = frame_i && (idx_i < len) && ext[pos];
  end

endmodule

// File: rtl/adc_sercfg.sv
module adc_sercfg
  import adc_sercfg_pkg::*;
#(
  parameter int unsigned RES_W       = 12,
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned SHORT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             conv_req_o,
  output logic [7:0]       cfg_o,
  output logic             busy_o,
  input  logic             core_done_i,
  input  logic [RES_W-1:0] core_result_i
);

  localparam int unsigned IDX_W = $clog2(OUT_W + 1);

  logic [2:0]       lvl;
  logic             frame;
  logic [IDX_W-1:0] out_idx;
  logic [RES_W-1:0] word;
  cfg_t             cfg;

  adc_sercfg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_ni, sck_i, sdi_i}),
    .level_o(lvl)
  );

  adc_sercfg_frame #(
    .RES_W(RES_W),
    .OUT_W(OUT_W)
  ) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_n_i       (lvl[2]),
    .sck_i        (lvl[1]),
    .sdi_i        (lvl[0]),
    .core_done_i  (core_done_i),
    .core_result_i(core_result_i),
    .frame_o      (frame),
    .out_idx_o    (out_idx),
    .word_o       (word),
    .cfg_o        (cfg),
    .busy_o       (busy_o),
    .conv_req_o   (conv_req_o)
  );

  adc_sercfg_fmt #(
    .RES_W  (RES_W),
    .OUT_W  (OUT_W),
    .SHORT_W(SHORT_W)
  ) u_fmt (
    .frame_i(frame),
    .word_i (word),
    .cfg_i  (cfg),
    .idx_i  (out_idx),
    .bit_o  (sdo_o)
  );

  assign cfg_o = cfg;

endmodule

// File: rtl/adc_sercfg_chk.sv
module adc_sercfg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sdo_o,
  input logic       conv_req_o,
  input logic [7:0] cfg_o,
  input logic       busy_o,
  input logic       core_done_i
);

  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);

  assert_req_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_o);

  assert_cfg_on_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> conv_req_o);

  assert_busy_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(core_done_i));

  assert_sdo_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_o);

endmodule

bind adc_sercfg adc_sercfg_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sdo_o      (sdo_o),
  .conv_req_o (conv_req_o),
  .cfg_o      (cfg_o),
  .busy_o     (busy_o),
  .core_done_i(core_done_i)
);

// File: tb/adc_sercfg_tb_top.sv
module adc_sercfg_tb_top;

  localparam int LAT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo_o;
  logic        conv_req_o;
  logic [7:0]  cfg_o;
  logic        busy_o;
  logic        core_done;
  logic [11:0] core_res;

  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int conv_cnt = 0;
  bit finished = 1'b0;

  bit          auto_en = 1'b1;
  int          cd = 0;
  int          seq = 0;
  logic        mdl_done = 1'b0;
  logic [11:0] mdl_res = '0;
  logic        man_done = 1'b0;
  logic [11:0] man_res = '0;

  assign core_done = mdl_done | man_done;
  assign core_res  = man_done ? man_res : mdl_res;

  adc_sercfg dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cs_ni        (cs_n),
    .sck_i        (sck),
    .sdi_i        (sdi),
    .sdo_o        (sdo_o),
    .conv_req_o   (conv_req_o),
    .cfg_o        (cfg_o),
    .busy_o       (busy_o),
    .core_done_i  (core_done),
    .core_result_i(core_res)
  );

  function automatic logic [11:0] gen(int k);
    return 12'((k * 693 + 241) % 4096);
  endfunction

  // expected 16 captured bits, first sample in bit 15
  function automatic logic [15:0] fmt(logic [11:0] r, logic [7:0] c);
    int len;
    logic [15:0] v, o;
    len = (c[1:0] == 2'b00) ? 8 : (c[1:0] == 2'b01) ? 12 : 16;
    v = {r, 4'b0000} >> (16 - len);
    o = '0;
    if (c[2]) o = v << (16 - len);
    else for (int i = 0; i < len; i++) o[15-i] = v[i];
    return o;
  endfunction

  always @(posedge clk) begin
    if (conv_req_o) conv_cnt <= conv_cnt + 1;
    mdl_done <= 1'b0;
    if (auto_en && conv_req_o) cd <= LAT;
    else if (cd > 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        mdl_done <= 1'b1;
        mdl_res  <= gen(seq);
        seq      <= seq + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_done(input logic [11:0] r);
    @(negedge clk);
    man_res  = r;
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] din, input int nbits, input bit collide,
                       input logic [11:0] cres, output logic [15:0] cap);
    cap = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = din[15-i];
      repeat (6) @(negedge clk);
      cap[15-i] = sdo_o;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    if (collide) begin
      // frame end is acted on at the third rising clock after cs_n rises
      @(negedge clk);
      @(negedge clk);
      man_res  = cres;
      man_done = 1'b1;
      @(negedge clk);
      man_done = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] cap;
    logic [7:0]  exp_cfg;
    logic [11:0] exp_store;
    int          rseq;
    int          cc;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(cfg_o == 8'h8D, "R1 cfg", 32'(cfg_o), 32'h8D);
    check(busy_o == 1'b0, "R1 busy", 32'(busy_o), 0);
    check(conv_req_o == 1'b0, "R1 req", 32'(conv_req_o), 0);
    check(sdo_o == 1'b0, "R1 R10 sdo idle", 32'(sdo_o), 0);
    exp_cfg   = 8'h8D;
    exp_store = '0;
    rseq      = 0;

    // R4 short frame
    frame(16'h5A00, 5, 1'b0, '0, cap);
    check(cfg_o == exp_cfg, "R4 cfg kept", 32'(cfg_o), 32'(exp_cfg));
    check(conv_cnt == 0, "R4 no request", 32'(conv_cnt), 0);
    check(busy_o == 1'b0, "R4 busy", 32'(busy_o), 0);

    // exhaustive sweep of configuration words; trailing bits inverted (R2)
    for (int w = 0; w < 256; w++) begin
      cc = conv_cnt;
      frame({8'(w), ~8'(w)}, 16, 1'b0, '0, cap);
      check(cap == fmt(exp_store, exp_cfg), "R6 R7 R8 R9 output word",
            32'(cap), 32'(fmt(exp_store, exp_cfg)));
      check(cfg_o == 8'(w), "R2 cfg capture", 32'(cfg_o), 32'(w));
      check(conv_cnt == cc + 1, "R3 one request", 32'(conv_cnt), 32'(cc + 1));
      check(busy_o == 1'b1, "R3 busy set", 32'(busy_o), 1);
      repeat (40) @(negedge clk);
      check(busy_o == 1'b0, "R5 busy cleared", 32'(busy_o), 0);
      check(sdo_o == 1'b0, "R10 sdo idle", 32'(sdo_o), 0);
      exp_store = gen(rseq);
      rseq++;
      exp_cfg = 8'(w);
    end

    auto_en = 1'b0;
    // R5 done while idle is ignored
    pulse_done(12'hABC);
    check(busy_o == 1'b0, "R5 idle done", 32'(busy_o), 0);

    // frame A: leaves a request outstanding
    cc = conv_cnt;
    frame({8'h56, 8'h00}, 16, 1'b0, '0, cap);
    check(cap == fmt(exp_store, exp_cfg), "R5 idle done ignored",
          32'(cap), 32'(fmt(exp_store, exp_cfg)));
    check(busy_o == 1'b1, "R3 busy A", 32'(busy_o), 1);
    exp_cfg = 8'h56;

    // frame B: done coincides with frame end
    cc = conv_cnt;
    frame({8'hA0, 8'hFF}, 16, 1'b1, 12'h5E7, cap);
    check(cap == fmt(exp_store, exp_cfg), "R11 output while busy",
          32'(cap), 32'(fmt(exp_store, exp_cfg)));
    check(conv_cnt == cc + 1, "R12 request accepted", 32'(conv_cnt), 32'(cc + 1));
    check(busy_o == 1'b1, "R12 busy kept", 32'(busy_o), 1);
    check(cfg_o == 8'hA0, "R12 cfg taken", 32'(cfg_o), 32'hA0);
    exp_store = 12'h5E7;
    exp_cfg   = 8'hA0;

    // frame C: while busy, dropped
    cc = conv_cnt;
    frame({8'hFF, 8'h00}, 16, 1'b0, '0, cap);
    check(cap == fmt(exp_store, exp_cfg), "R12 collided result stored",
          32'(cap), 32'(fmt(exp_store, exp_cfg)));
    check(cfg_o == 8'hA0, "R11 cfg unchanged", 32'(cfg_o), 32'hA0);
    check(conv_cnt == cc, "R11 no request", 32'(conv_cnt), 32'(cc));

    pulse_done(12'h39A);
    check(busy_o == 1'b0, "R5 busy cleared by done", 32'(busy_o), 0);
    exp_store = 12'h39A;

    // frame D
    cc = conv_cnt;
    frame({8'h0F, 8'hF0}, 16, 1'b0, '0, cap);
    check(cap == fmt(exp_store, exp_cfg), "R6 pipelined result",
          32'(cap), 32'(fmt(exp_store, exp_cfg)));
    check(cfg_o == 8'h0F, "R3 cfg D", 32'(cfg_o), 32'h0F);
    check(conv_cnt == cc + 1, "R3 request D", 32'(conv_cnt), 32'(cc + 1));
    pulse_done(12'h123);
    check(busy_o == 1'b0, "R5 final", 32'(busy_o), 0);
    check(sdo_o == 1'b0, "R10 final idle", 32'(sdo_o), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule